// File: doc/BRIEF.md
# Chained Vector Multiply-Add Unit

This block evaluates S(i) = A * X(i) + Y(i) across a vector of integer elements. Two operand register banks, one for X and one for Y, each hold 64 words and are filled through their own write ports. A single command pulse carries the scalar A and the total element count. The unit splits that count into strips of at most 64 elements. Each strip reads bank entries 0 upward. Every element passes through a fully segmented four-stage multiplier. The multiplier's last stage feeds a fully segmented four-stage adder directly, so the two units behave as one eight-stage pipe. Each result leaves on the result-register write port together with its element index.

A sequencer steps through five named states. IDLE waits for a command. ISSUE sends one element per cycle into the pipe. DRAIN lets the pipe empty between strips. FINISH lets the pipe empty after the final strip. DONE raises the completion flag for one cycle. The transitions are:
- LAUNCH: IDLE or DONE to ISSUE, on a command with a non-zero count.
- EMPTY: IDLE or DONE to DONE, on a command with a count of zero.
- STRIP_END: ISSUE to DRAIN, after the 64th element of a strip when elements remain.
- LAST: ISSUE to FINISH, after the final element.
- REFILL: DRAIN to ISSUE, once the pipe is empty.
- RETIRE: FINISH to DONE, once the pipe is empty.
- REST: DONE to IDLE, when no new command arrives.

Because every strip refills the pipe from empty, a short tail strip (one element after 64, for example) pays the whole startup latency again.

Top module: `vmac_chain`

## Requirements
- R1: Each result equals the low 32 bits of scalar_a * X[i] + Y[i], computed in two's-complement arithmetic with wraparound. The product is truncated to 32 bits before the addition.
- R2: When a command with a non-zero count is sampled at clock edge E, the element at strip index k appears with res_we high in the cycle that follows edge E+8+k.
- R3: Within a strip, results come out on consecutive cycles with res_addr counting 0, 1, 2 and so on. No write appears at any other time.
- R4: A count L above 64 is processed as successive strips of 64 elements followed by a final strip of the remainder. Every strip reads operand entries starting at entry 0.
- R5: After a strip's final result, the first result of the next strip appears 9 cycles later, because the pipe is drained and refilled.
- R6: done is high for exactly one cycle, in the cycle right after the final result. No result is written in that cycle.
- R7: A command with a count of zero produces no writes and raises done in the cycle after it is sampled.
- R8: A command arriving while the unit is busy is ignored. The count and scalar are captured only when a command is accepted.
- R9: Writes to either operand bank while the unit is busy are ignored, so the bank keeps its earlier contents.
- R10: During reset, res_we and done are low.
- R11: A command may be accepted in the same cycle that done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command pulse |
| vec_len | input | 16 | Total element count of the command |
| scalar_a | input | 32 | Scalar multiplier A |
| x_we | input | 1 | X bank write enable |
| x_waddr | input | 6 | X bank write address |
| x_wdata | input | 32 | X bank write data |
| y_we | input | 1 | Y bank write enable |
| y_waddr | input | 6 | Y bank write address |
| y_wdata | input | 32 | Y bank write data |
| res_we | output | 1 | Result register write enable |
| res_addr | output | 6 | Result register element index |
| res_data | output | 32 | Result value |
| done | output | 1 | Command complete, one-cycle pulse |

## Verification
The bench builds the unit with its default parameters: 32-bit words, 64-entry banks, and four multiply plus four add stages. With these values, commands of 0, 5, 64, 65 and 130 elements exercise the empty command, a single partial strip, an exactly full strip, a one-element tail, and a three-strip run ending in a two-element tail. The operand values are chosen near the positive and negative limits so that the truncated product and the final addition both wrap. A command launched in the done cycle also places two runs back to back with no idle cycle between them.

// File: rtl/vmac_pkg.sv
`timescale 1ns/1ps
package vmac_pkg;

    // Sequencer states of the chained multiply-add unit.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/vmac_vreg.sv
`timescale 1ns/1ps
// One operand vector register: a single write port, gated while a run is
// active, and an asynchronous read port for the issue stage.
module vmac_vreg #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_lock,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && !wr_lock) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/vmac_seq.sv
`timescale 1ns/1ps
// Strip-mining sequencer: accepts a command, issues one element per cycle,
// drains the pipe between strips and pulses done after the final write.
module vmac_seq
    import vmac_pkg::*;
#(
    parameter int VLEN       = 64,
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 32,
    parameter int PIPE_DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LEN_W-1:0]        vec_len,
    input  logic [DATA_W-1:0]       scalar_a,
    output logic                    issue_valid,
    output logic [$clog2(VLEN)-1:0] issue_idx,
    output logic [DATA_W-1:0]       a_hold,
    output logic                    busy,
    output logic                    done
);

    localparam int IDX_W = $clog2(VLEN);
    localparam int CNT_W = $clog2(PIPE_DEPTH);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [LEN_W-1:0]  rem_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  wait_q;
    logic [DATA_W-1:0] a_q;

    logic accept;
    logic strip_full;
    logic last_elem;
    logic empty_cmd;

    assign accept     = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign strip_full = (idx_q == IDX_W'(VLEN - 1));
    assign last_elem  = (rem_q == LEN_W'(1));
    assign empty_cmd  = (vec_len == '0);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = empty_cmd ? ST_DONE : ST_ISSUE;   // EMPTY / LAUNCH
                end
            end
            ST_ISSUE: begin
                if (last_elem) begin
                    state_d = ST_FINISH;                        // LAST
                end else if (strip_full) begin
                    state_d = ST_DRAIN;                         // STRIP_END
                end
            end
            ST_DRAIN: begin
                if (wait_q == '0) begin
                    state_d = ST_ISSUE;                         // REFILL
                end
            end
            ST_FINISH: begin
                if (wait_q == '0) begin
                    state_d = ST_DONE;                          // RETIRE
                end
            end
            ST_DONE: begin
                if (start) begin
                    state_d = empty_cmd ? ST_DONE : ST_ISSUE;   // EMPTY / LAUNCH
                end else begin
                    state_d = ST_IDLE;                          // REST
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the counters that travel with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            idx_q   <= '0;
            wait_q  <= '0;
            a_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rem_q <= vec_len;
                idx_q <= '0;
                a_q   <= scalar_a;
            end else if (state_q == ST_ISSUE) begin
                rem_q  <= rem_q - 1'b1;
                idx_q  <= strip_full ? '0 : idx_q + 1'b1;
                wait_q <= CNT_W'(PIPE_DEPTH - 1);
            end else if (wait_q != '0) begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        issue_valid = (state_q == ST_ISSUE);
        issue_idx   = idx_q;
        a_hold      = a_q;
        busy        = (state_q == ST_ISSUE) || (state_q == ST_DRAIN) || (state_q == ST_FINISH);
        done        = (state_q == ST_DONE);
    end

endmodule

// File: rtl/vmac_mul_pipe.sv
`timescale 1ns/1ps
// Fully segmented multiplier. Stage k adds the partial product of X and one
// SLICE-bit digit of A, so each stage does a fixed share of the work and a
// new element may enter every cycle. DATA_W must be a multiple of STAGES.
module vmac_mul_pipe #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_y,
    input  logic [DATA_W-1:0] a,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_prod,
    output logic [DATA_W-1:0] out_y
);

    localparam int SLICE = DATA_W / STAGES;

    typedef struct packed {
        logic              v;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] acc;
    } mstage_t;

    mstage_t head;
    mstage_t pipe_q [STAGES];

    function automatic mstage_t mul_step(mstage_t s, int k, logic [DATA_W-1:0] av);
        mstage_t           r;
        logic [DATA_W-1:0] part;
        r     = s;
        part  = s.x * DATA_W'(av[k*SLICE +: SLICE]);
        r.acc = s.acc + (part << (k * SLICE));
        return r;
    endfunction

    always_comb begin
        head = '{v: in_valid, idx: in_idx, x: in_x, y: in_y, acc: '0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                pipe_q[k] <= '0;
            end
        end else begin
            pipe_q[0] <= mul_step(head, 0, a);
            for (int k = 1; k < STAGES; k++) begin
                pipe_q[k] <= mul_step(pipe_q[k-1], k, a);
            end
        end
    end

    assign out_valid = pipe_q[STAGES-1].v;
    assign out_idx   = pipe_q[STAGES-1].idx;
    assign out_prod  = pipe_q[STAGES-1].acc;
    assign out_y     = pipe_q[STAGES-1].y;

endmodule

// File: rtl/vmac_add_pipe.sv
`timescale 1ns/1ps
// Fully segmented adder. Stage j sums one SLICE-bit digit of product and
// addend with the carry left by stage j-1. DATA_W must be a multiple of STAGES.
module vmac_add_pipe #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  in_idx,
    input  logic [DATA_W-1:0] in_prod,
    input  logic [DATA_W-1:0] in_y,
    output logic              out_valid,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_sum
);

    localparam int SLICE = DATA_W / STAGES;

    typedef struct packed {
        logic              v;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] prod;
        logic [DATA_W-1:0] y;
        logic [DATA_W-1:0] sum;
        logic              carry;
    } astage_t;

    astage_t head;
    astage_t pipe_q [STAGES];

    function automatic astage_t add_step(astage_t s, int j);
        astage_t        r;
        logic [SLICE:0] t;
        r = s;
        t = {1'b0, s.prod[j*SLICE +: SLICE]}
          + {1'b0, s.y[j*SLICE +: SLICE]}
          + {{SLICE{1'b0}}, s.carry};
        r.sum[j*SLICE +: SLICE] = t[SLICE-1:0];
        r.carry                 = t[SLICE];
        return r;
    endfunction

    always_comb begin
        head = '{v: in_valid, idx: in_idx, prod: in_prod, y: in_y, sum: '0, carry: 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < STAGES; j++) begin
                pipe_q[j] <= '0;
            end
        end else begin
            pipe_q[0] <= add_step(head, 0);
            for (int j = 1; j < STAGES; j++) begin
                pipe_q[j] <= add_step(pipe_q[j-1], j);
            end
        end
    end

    assign out_valid = pipe_q[STAGES-1].v;
    assign out_idx   = pipe_q[STAGES-1].idx;
    assign out_sum   = pipe_q[STAGES-1].sum;

endmodule

// File: rtl/vmac_chain.sv
`timescale 1ns/1ps
// Chained vector multiply-add: S(i) = A * X(i) + Y(i). The multiplier's last
// register drives the adder's first stage directly, forming one pipe of
// MUL_STAGES + ADD_STAGES segments.
module vmac_chain #(
    parameter int DATA_W     = 32,
    parameter int VLEN       = 64,
    parameter int LEN_W      = 16,
    parameter int MUL_STAGES = 4,
    parameter int ADD_STAGES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LEN_W-1:0]        vec_len,
    input  logic [DATA_W-1:0]       scalar_a,
    input  logic                    x_we,
    input  logic [$clog2(VLEN)-1:0] x_waddr,
    input  logic [DATA_W-1:0]       x_wdata,
    input  logic                    y_we,
    input  logic [$clog2(VLEN)-1:0] y_waddr,
    input  logic [DATA_W-1:0]       y_wdata,
    output logic                    res_we,
    output logic [$clog2(VLEN)-1:0] res_addr,
    output logic [DATA_W-1:0]       res_data,
    output logic                    done
);

    localparam int IDX_W      = $clog2(VLEN);
    localparam int PIPE_DEPTH = MUL_STAGES + ADD_STAGES;

    logic              issue_v;
    logic [IDX_W-1:0]  issue_idx;
    logic [DATA_W-1:0] a_hold;
    logic              busy;
    logic [DATA_W-1:0] x_rd;
    logic [DATA_W-1:0] y_rd;

    logic              m_valid;
    logic [IDX_W-1:0]  m_idx;
    logic [DATA_W-1:0] m_prod;
    logic [DATA_W-1:0] m_y;

    vmac_seq #(
        .VLEN       (VLEN),
        .LEN_W      (LEN_W),
        .DATA_W     (DATA_W),
        .PIPE_DEPTH (PIPE_DEPTH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vec_len     (vec_len),
        .scalar_a    (scalar_a),
        .issue_valid (issue_v),
        .issue_idx   (issue_idx),
        .a_hold      (a_hold),
        .busy        (busy),
        .done        (done)
    );

    vmac_vreg #(.DEPTH(VLEN), .DATA_W(DATA_W)) u_xbank (
        .clk     (clk),
        .wr_en   (x_we),
        .wr_lock (busy),
        .wr_addr (x_waddr),
        .wr_data (x_wdata),
        .rd_addr (issue_idx),
        .rd_data (x_rd)
    );

    vmac_vreg #(.DEPTH(VLEN), .DATA_W(DATA_W)) u_ybank (
        .clk     (clk),
        .wr_en   (y_we),
        .wr_lock (busy),
        .wr_addr (y_waddr),
        .wr_data (y_wdata),
        .rd_addr (issue_idx),
        .rd_data (y_rd)
    );

    vmac_mul_pipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STAGES(MUL_STAGES)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (issue_v),
        .in_idx    (issue_idx),
        .in_x      (x_rd),
        .in_y      (y_rd),
        .a         (a_hold),
        .out_valid (m_valid),
        .out_idx   (m_idx),
        .out_prod  (m_prod),
        .out_y     (m_y)
    );

    // Chaining: the multiplier output enters the adder with no extra register.
    vmac_add_pipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .STAGES(ADD_STAGES)) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (m_valid),
        .in_idx    (m_idx),
        .in_prod   (m_prod),
        .in_y      (m_y),
        .out_valid (res_we),
        .out_idx   (res_addr),
        .out_sum   (res_data)
    );

endmodule

// File: rtl/vmac_chain_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks, bound into every vmac_chain instance.
module vmac_chain_chk #(
    parameter int IDX_W      = 6,
    parameter int PIPE_DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             res_we,
    input logic [IDX_W-1:0] res_addr,
    input logic             done
);

    int   gap_q;
    logic seen_q;

    // Cycles since the last result write, saturating; seen_q marks a run
    // that has already produced a write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else begin
            if (res_we) begin
                gap_q <= 0;
            end else if (gap_q < PIPE_DEPTH + 1) begin
                gap_q <= gap_q + 1;
            end
            if (done) begin
                seen_q <= 1'b0;
            end else if (res_we) begin
                seen_q <= 1'b1;
            end
        end
    end

    // R3: a burst of writes begins at element 0.
    assert_strip_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !$past(res_we)) |-> (res_addr == '0));

    // R3: back-to-back writes step the element index by one.
    assert_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && $past(res_we)) |-> (res_addr == IDX_W'($past(res_addr) + 1'b1)));

    // R5: a later strip of the same run starts only after a full refill.
    assert_refill_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && !$past(res_we) && seen_q) |-> (gap_q >= PIPE_DEPTH));

    // R6: done lasts one cycle unless an empty command restarts it.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    // R6: no write lands in the done cycle.
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !res_we);

endmodule

bind vmac_chain vmac_chain_chk #(
    .IDX_W      (IDX_W),
    .PIPE_DEPTH (PIPE_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .res_we   (res_we),
    .res_addr (res_addr),
    .done     (done)
);

// File: tb/vmac_chain_tb.sv
`timescale 1ns/1ps
module vmac_chain_tb;

    localparam int DATA_W = 32;
    localparam int VLEN   = 64;
    localparam int LEN_W  = 16;
    localparam int IDX_W  = 6;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [LEN_W-1:0]  vec_len;
    logic [DATA_W-1:0] scalar_a;
    logic              x_we;
    logic [IDX_W-1:0]  x_waddr;
    logic [DATA_W-1:0] x_wdata;
    logic              y_we;
    logic [IDX_W-1:0]  y_waddr;
    logic [DATA_W-1:0] y_wdata;
    logic              res_we;
    logic [IDX_W-1:0]  res_addr;
    logic [DATA_W-1:0] res_data;
    logic              done;

    always #2 clk = ~clk;   // 250 MHz

    vmac_chain u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .vec_len  (vec_len),
        .scalar_a (scalar_a),
        .x_we     (x_we),
        .x_waddr  (x_waddr),
        .x_wdata  (x_wdata),
        .y_we     (y_we),
        .y_waddr  (y_waddr),
        .y_wdata  (y_wdata),
        .res_we   (res_we),
        .res_addr (res_addr),
        .res_data (res_data),
        .done     (done)
    );

    // Reference model state.
    int                edge_n = 0;
    int                checks = 0;
    int                errors = 0;
    int                busy_end = -1;
    logic [DATA_W-1:0] xm [VLEN];
    logic [DATA_W-1:0] ym [VLEN];
    logic [DATA_W-1:0] exp_data [int];
    logic [IDX_W-1:0]  exp_addr [int];
    string             exp_tag  [int];
    string             exp_dtag [int];
    string             done_tag [int];

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic fail(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        errors++;
        $display("FAIL %s %s: actual %h expected %h (edge %0d)", tag, what, act, exp, edge_n);
    endtask

    function automatic bit model_idle(int e);
        return e > busy_end;
    endfunction

    // Schedule the writes and the done pulse of a command sampled at edge e0.
    task automatic model_launch(int e0, int len, logic [DATA_W-1:0] a, string dtag);
        int b;
        int rem;
        int n;
        bit first;
        b = e0;
        rem = len;
        n = 0;
        first = 1'b1;
        if (len == 0) begin
            done_tag[e0] = "R7";
            busy_end = e0;
            return;
        end
        while (rem > 0) begin
            n = (rem > VLEN) ? VLEN : rem;
            for (int k = 0; k < n; k++) begin
                int key;
                key = b + DEPTH + k;
                exp_data[key] = a * xm[k] + ym[k];
                exp_addr[key] = IDX_W'(k);
                exp_tag[key]  = (k != 0) ? "R3" : (first ? "R2" : "R5");
                exp_dtag[key] = dtag;
            end
            first = 1'b0;
            rem -= n;
            if (rem > 0) b = b + n + DEPTH;
        end
        done_tag[b + n + DEPTH] = "R6";
        busy_end = b + n + DEPTH;
    endtask

    // Comparison against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            bit de;
            checks++;
            if (exp_data.exists(edge_n)) begin
                if (res_we !== 1'b1 || res_addr !== exp_addr[edge_n])
                    fail(exp_tag[edge_n], "write/index", {25'd0, res_we, res_addr}, {25'd0, 1'b1, exp_addr[edge_n]});
                checks++;
                if (res_data !== exp_data[edge_n])
                    fail(exp_dtag[edge_n], "result value", res_data, exp_data[edge_n]);
            end else if (res_we !== 1'b0) begin
                fail("R3", "unexpected write", {25'd0, res_we, res_addr}, '0);
            end
            checks++;
            de = done_tag.exists(edge_n);
            if (done !== de)
                fail(de ? done_tag[edge_n] : "R6", "done", {31'd0, done}, {31'd0, de});
        end
    end

    // Called at a falling edge; drives a command for the next rising edge.
    task automatic kick(int len, logic [DATA_W-1:0] a, string dtag);
        start    = 1'b1;
        vec_len  = LEN_W'(len);
        scalar_a = a;
        if (model_idle(edge_n + 1)) model_launch(edge_n + 1, len, a, dtag);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic write_pair(int addr, logic [DATA_W-1:0] xv, logic [DATA_W-1:0] yv);
        x_we    = 1'b1;
        y_we    = 1'b1;
        x_waddr = IDX_W'(addr);
        y_waddr = IDX_W'(addr);
        x_wdata = xv;
        y_wdata = yv;
        if (model_idle(edge_n + 1)) begin
            xm[addr] = xv;
            ym[addr] = yv;
        end
        @(negedge clk);
        x_we = 1'b0;
        y_we = 1'b0;
    endtask

    task automatic wait_quiet();
        while (edge_n <= busy_end + 2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual hung expected finished run");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        start    = 1'b0;
        vec_len  = '0;
        scalar_a = '0;
        x_we     = 1'b0;
        y_we     = 1'b0;
        x_waddr  = '0;
        y_waddr  = '0;
        x_wdata  = '0;
        y_wdata  = '0;

        // R10: outputs quiet while reset is held.
        repeat (3) @(negedge clk);
        checks++;
        if (res_we !== 1'b0 || done !== 1'b0)
            fail("R10", "reset outputs", {30'd0, res_we, done}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill both banks with values near the signed limits.
        for (int i = 0; i < VLEN; i++) begin
            write_pair(i, 32'h7FFF_FFF0 + i * 32'h0101_0101,
                          32'hFFFF_0000 ^ (i * 32'h0003_0007));
        end
        @(negedge clk);

        // R1, R2, R3, R6: short partial strip.
        kick(5, 32'd3, "R1");
        wait_quiet();

        // R1: full strip with a negative scalar.
        kick(64, 32'hFFFF_FFFD, "R1");
        wait_quiet();

        // R4, R5: one-element tail strip.
        kick(65, 32'h1234_5678, "R4");
        wait_quiet();

        // R4, R5: three strips, tail of two.
        kick(130, 32'h8000_0001, "R4");
        wait_quiet();

        // R7: empty command.
        kick(0, 32'd7, "R7");
        wait_quiet();

        // R8: a second command and changed inputs during a run are ignored.
        kick(10, 32'd5, "R8");
        repeat (2) @(negedge clk);
        kick(50, 32'd99, "R8");
        vec_len  = LEN_W'(33);
        scalar_a = 32'h0BAD_0BAD;
        wait_quiet();

        // R9: bank writes during a run leave the banks unchanged.
        kick(20, 32'd2, "R9");
        @(negedge clk);
        write_pair(3, 32'hDEAD_BEEF, 32'hCAFE_F00D);
        write_pair(0, 32'h1111_1111, 32'h2222_2222);
        wait_quiet();
        kick(8, 32'd1, "R9");
        wait_quiet();

        // R11: new command accepted in the done cycle.
        kick(3, 32'd4, "R11");
        while (edge_n < busy_end) @(negedge clk);
        kick(6, 32'd9, "R11");
        wait_quiet();

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule